// File: doc/BRIEF.md
# Word-level four-to-two carry-save compressor row

This block reduces four unsigned operand words of equal width to a pair of vectors, a sum word and a carry word, whose arithmetic total equals the exact total of the four operands. It is purely combinational. It is meant as one level of a partial-product reduction tree or a multi-operand adder. A separate carry-propagate adder downstream turns the pair into a single binary result.

The row is built from identical bit slices. Each slice takes four operand bits and a lateral carry from the slice one position below. It returns a sum bit, a carry bit and a lateral carry for the slice one position above. The lateral carry a slice emits is formed from three of its operand bits only and never from its incoming lateral carry, so no carry ripples along the row. The delay stays that of a single slice whatever the width.

Inside a slice, the four-bit parity is formed by two levels of XOR. The sum bit is a third XOR with the incoming lateral carry. The carry bit is chosen by a multiplexer that the parity steers. The longest path is therefore three XOR stages, where two chained full adders would need four. No state machine and no clock are involved: every output follows the inputs within the same cycle.

Top module: `cmp42_row`

## Requirements
- R1: For any four N-bit unsigned operands, `sum_o + carry_o`, taken as an (N+2)-bit addition, equals `op_a_i + op_b_i + op_c_i + op_d_i` exactly.
- R2: The lowest slice has its lateral carry-in tied to zero, so `sum_o[0]` equals the XOR of bit 0 of all four operands.
- R3: Each slice's lateral carry-out is the majority of its bits of `op_a_i`, `op_b_i` and `op_c_i`, independent of lower bits. The top slice's carry-out appears as `sum_o[N]`, so `sum_o[N]` equals the majority of `op_a_i[N-1]`, `op_b_i[N-1]` and `op_c_i[N-1]`.
- R4: `carry_o` is weighted one position higher than the slices, so `carry_o[0]` is always 0 and `carry_o[i+1]` holds the carry bit of slice i.
- R5: Every slice i satisfies `a[i]+b[i]+c[i]+d[i]+cin[i] = sum_o[i] + 2*(carry_o[i+1] + cout[i])`, where `cin[0]` is 0 and `cin[i]` is `cout[i-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | N | First operand word |
| op_b_i | input | N | Second operand word |
| op_c_i | input | N | Third operand word |
| op_d_i | input | N | Fourth operand word |
| sum_o | output | N+1 | Sum vector; bit N carries the top slice's lateral carry-out |
| carry_o | output | N+1 | Carry vector, weighted one position above the slices; bit 0 is zero |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between the operand inputs and either output vector. The bench changes the operands just after a rising clock edge and samples both output vectors half a period later, on the falling edge, so the combinational network has settled and no sample falls on an edge where inputs move. The bit-0 parity, the top majority bit, the zero weight-one carry bit and the lowest-slice identity are each checked in that same sampling window, next to the word total.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;

    // Outputs of one compressor slice.
    typedef struct packed {
        logic sum;
        logic carry;
        logic lat_out;
    } slice_res_t;

    localparam int unsigned DEF_WIDTH = 16;

endpackage

// File: rtl/cmp42_maj3.sv
module cmp42_maj3 (
    input  logic in0_i,
    input  logic in1_i,
    input  logic in2_i,
    output logic maj_o
);

    always_comb begin
        maj_o = (in0_i & in1_i) | (in0_i & in2_i) | (in1_i & in2_i);
    end

endmodule

// File: rtl/cmp42_mux2.sv
module cmp42_mux2 (
    input  logic sel_i,
    input  logic when0_i,
    input  logic when1_i,
    output logic out_o
);

    always_comb begin
        out_o = sel_i ? when1_i : when0_i;
    end

endmodule

// File: rtl/cmp42_slice.sv
module cmp42_slice
    import cmp42_pkg::*;
(
    input  logic       x1_i,
    input  logic       x2_i,
    input  logic       x3_i,
    input  logic       x4_i,
    input  logic       lat_in_i,
    output slice_res_t res_o
);

    logic pair_lo;
    logic pair_hi;
    logic parity4;
    logic lat_out;
    logic carry_bit;

    // XOR level 1 (two gates in parallel).
    always_comb begin
        pair_lo = x1_i ^ x2_i;
        pair_hi = x3_i ^ x4_i;
    end

    // XOR level 2: four-bit parity.
    always_comb begin
        parity4 = pair_lo ^ pair_hi;
    end

    // Lateral carry-out from operand bits alone.
    cmp42_maj3 u_maj (
        .in0_i (x1_i),
        .in1_i (x2_i),
        .in2_i (x3_i),
        .maj_o (lat_out)
    );

    // Carry bit: lateral carry-in when parity is set, else fourth bit.
    cmp42_mux2 u_csel (
        .sel_i   (parity4),
        .when0_i (x4_i),
        .when1_i (lat_in_i),
        .out_o   (carry_bit)
    );

    // XOR level 3: sum bit.
    always_comb begin
        res_o.sum     = parity4 ^ lat_in_i;
        res_o.carry   = carry_bit;
        res_o.lat_out = lat_out;
    end

endmodule

// File: rtl/cmp42_row.sv
module cmp42_row
    import cmp42_pkg::*;
#(
    parameter int unsigned N = DEF_WIDTH
) (
    input  logic [N-1:0] op_a_i,
    input  logic [N-1:0] op_b_i,
    input  logic [N-1:0] op_c_i,
    input  logic [N-1:0] op_d_i,
    output logic [N:0]   sum_o,
    output logic [N:0]   carry_o
);

    localparam int unsigned OUT_W = N + 1;

    slice_res_t       res  [N];
    logic [N-1:0]     lat_in;
    logic [N-1:0]     lat_out;
    logic [N-1:0]     s_bits;
    logic [N-1:0]     c_bits;

    for (genvar i = 0; i < N; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            assign lat_in[i] = 1'b0;
        end else begin : g_upper
            assign lat_in[i] = lat_out[i-1];
        end

        cmp42_slice u_slice (
            .x1_i     (op_a_i[i]),
            .x2_i     (op_b_i[i]),
            .x3_i     (op_c_i[i]),
            .x4_i     (op_d_i[i]),
            .lat_in_i (lat_in[i]),
            .res_o    (res[i])
        );

        assign s_bits[i]  = res[i].sum;
        assign c_bits[i]  = res[i].carry;
        assign lat_out[i] = res[i].lat_out;
    end

    always_comb begin
        sum_o   = {lat_out[N-1], s_bits};
        carry_o = {c_bits, 1'b0};
    end

    logic [OUT_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/cmp42_row_chk.sv
module cmp42_row_chk #(
    parameter int unsigned N = 16
) (
    input logic [N-1:0] op_a_i,
    input logic [N-1:0] op_b_i,
    input logic [N-1:0] op_c_i,
    input logic [N-1:0] op_d_i,
    input logic [N:0]   sum_o,
    input logic [N:0]   carry_o,
    input logic [N-1:0] lat_in,
    input logic [N-1:0] lat_out
);

    logic [N+1:0] op_total;
    logic [N+1:0] vec_total;

    always_comb begin
        op_total  = {2'b00, op_a_i} + {2'b00, op_b_i}
                  + {2'b00, op_c_i} + {2'b00, op_d_i};
        vec_total = {1'b0, sum_o} + {1'b0, carry_o};
    end

    always_comb begin
        // R1
        a_r1_exact_total: assert (vec_total == op_total);
        // R2
        a_r2_lsb_parity: assert (sum_o[0] == (op_a_i[0] ^ op_b_i[0] ^ op_c_i[0] ^ op_d_i[0]));
        // R3
        a_r3_top_lateral: assert (sum_o[N] == lat_out[N-1]);
        // R4
        a_r4_carry_lsb_zero: assert (carry_o[0] == 1'b0);
    end

    always_comb begin
        for (int i = 0; i < int'(N); i++) begin
            // R5
            a_r5_slice_identity: assert (
                ({2'b00, op_a_i[i]} + {2'b00, op_b_i[i]} + {2'b00, op_c_i[i]}
                 + {2'b00, op_d_i[i]} + {2'b00, lat_in[i]})
                == ({2'b00, sum_o[i]} + {1'b0, carry_o[i+1], 1'b0} + {1'b0, lat_out[i], 1'b0}));
        end
    end

endmodule

bind cmp42_row cmp42_row_chk #(.N(N)) u_chk (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .op_c_i  (op_c_i),
    .op_d_i  (op_d_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .lat_in  (lat_in),
    .lat_out (lat_out)
);

// File: tb/cmp42_row_bench.sv
module cmp42_row_bench;

    localparam int unsigned N      = 16;
    localparam int unsigned NVEC   = 6;
    localparam int unsigned NRAND  = 200;

    typedef struct packed {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] c;
        logic [N-1:0] d;
        logic [N+1:0] total;
    } vec_t;

    localparam vec_t TABLE [NVEC] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 18'h00000},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 18'h3FFFC},
        '{16'h0001, 16'h0001, 16'h0001, 16'h0001, 18'h00004},
        '{16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 18'h10000},
        '{16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 18'h1E258},
        '{16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, 18'h1FFFE}
    };

    logic         clk;
    logic [N-1:0] op_a, op_b, op_c, op_d;
    logic [N:0]   sum_v, carry_v;

    int n_checks = 0;
    int n_fail   = 0;

    cmp42_row #(.N(N)) u_cmp42_row (
        .op_a_i  (op_a),
        .op_b_i  (op_b),
        .op_c_i  (op_c),
        .op_d_i  (op_d),
        .sum_o   (sum_v),
        .carry_o (carry_v)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [N+1:0] act, input logic [N+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic maj(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] c, input logic [N-1:0] d,
                         input logic [N+1:0] total);
        logic [2:0] lhs0;
        logic [2:0] rhs0;
        @(posedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d;
        @(negedge clk);
        // R1 word total
        chk("R1", {1'b0, sum_v} + {1'b0, carry_v}, total);
        // R2 lowest-slice parity
        chk("R2", {{(N+1){1'b0}}, sum_v[0]}, {{(N+1){1'b0}}, a[0] ^ b[0] ^ c[0] ^ d[0]});
        // R3 top lateral carry is majority of top bits of a, b, c
        chk("R3", {{(N+1){1'b0}}, sum_v[N]}, {{(N+1){1'b0}}, maj(a[N-1], b[N-1], c[N-1])});
        // R4 weight-one carry bit is zero
        chk("R4", {{(N+1){1'b0}}, carry_v[0]}, '0);
        // R5 slice-0 identity with cin=0 and cout=maj
        lhs0 = {2'b00, a[0]} + {2'b00, b[0]} + {2'b00, c[0]} + {2'b00, d[0]};
        rhs0 = {2'b00, sum_v[0]} + {1'b0, carry_v[1], 1'b0} + {1'b0, maj(a[0], b[0], c[0]), 1'b0};
        chk("R5", {{(N-1){1'b0}}, rhs0}, {{(N-1){1'b0}}, lhs0});
    endtask

    initial begin
        op_a = '0; op_b = '0; op_c = '0; op_d = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // Idle state with zero operands: R4 and R1
        chk("R4", {1'b0, carry_v}, '0);
        chk("R1", {1'b0, sum_v}, '0);

        for (int k = 0; k < int'(NVEC); k++) begin
            apply(TABLE[k].a, TABLE[k].b, TABLE[k].c, TABLE[k].d, TABLE[k].total);
        end

        // R3: top majority unchanged while lower bits sweep (no ripple from below)
        for (int k = 0; k < 8; k++) begin
            logic [N-1:0] lo;
            lo = N'($urandom) & 16'h7FFF;
            apply(16'h8000 | lo, 16'h8000 | ~lo & 16'h7FFF, lo, 16'hFFFF,
                  {2'b00, 16'h8000 | lo} + {2'b00, 16'h8000 | (~lo & 16'h7FFF)}
                  + {2'b00, lo} + 18'h0FFFF);
        end

        for (int k = 0; k < int'(NRAND); k++) begin
            logic [N-1:0] ra, rb, rc, rd;
            ra = N'($urandom); rb = N'($urandom);
            rc = N'($urandom); rd = N'($urandom);
            apply(ra, rb, rc, rd, {2'b00, ra} + {2'b00, rb} + {2'b00, rc} + {2'b00, rd});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule